// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Inter-Packet Gap Timer

This block decides the cycle in which a half-duplex transmit MAC may begin sending a frame. It watches carrier sense and applies a two-part inter-packet gap measured in bit times. In the first part, any return of carrier sends the block back to deferring. The second part runs to its end whatever the carrier does. After the gap, the block also waits until the transmit FIFO reports that its fill level is above the drain threshold. It then issues a one-cycle start pulse. The preamble and start-frame delimiter logic downstream uses that pulse to begin the frame.

The two gap lengths come in as a first-part length and a total gap length, both counted in bit times. A typical total is 96. Time advances only on a bit-time tick, which is supplied by the transmit clocking logic. A deferring status output tells the rest of the MAC that the block is still waiting on the medium.

Top module: `tx_defer_ipg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the block is idle, tx_start_o is 0 and deferring_o is 0.
- R2: A request (frame_req_i = 1) seen while idle starts deferral. While carrier_i is 1 after the request, deferring_o is 1 and tx_start_o stays 0.
- R3: Once carrier_i is 0, carrier must stay 0 for gap_part1_i bit ticks. If carrier_i is 1 at any clock edge in this first part, the block returns to deferral and measures the whole gap again.
- R4: After the first part, the block counts a second part of (gap_total_i − gap_part1_i) bit ticks. Carrier is ignored during this part, and deferring_o is 0 throughout it.
- R5: When gap_total_i is less than or equal to gap_part1_i, the second part has zero length.
- R6: tx_start_o is raised only after fifo_ready_i has been seen at 1 on the clock edge that ends the gap wait. If the flag is 0, the block holds after the gap until it rises.
- R7: The gap counters advance only on edges where bit_tick_i is 1. With the tick held at 0, no start occurs.
- R8: tx_start_o is high for exactly one cycle per frame. After it, the block is idle and samples frame_req_i again.
- R9: With bit_tick_i held at 1, carrier at 0 and the FIFO ready, tx_start_o goes high on the edge gap_part1_i + L2 + 3 edges after the edge that samples the request. Here L2 is the second-part length from R4/R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_i | input | 1 | Carrier sense from the medium |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| gap_part1_i | input | CNT_W | First gap part length, in bit times |
| gap_total_i | input | CNT_W | Total gap length, in bit times |
| fifo_ready_i | input | 1 | Transmit FIFO level is above the drain threshold |
| frame_req_i | input | 1 | A frame is pending for transmission |
| tx_start_o | output | 1 | One-cycle pulse to begin preamble |
| deferring_o | output | 1 | High while deferring or in the first gap part |

## Verification
Carrier sense and gap counting meet at the end of the first gap part. The last counting edge and the return of carrier can fall in the same cycle, and the carrier must win and restart deferral. The bench raises carrier at chosen edges inside the first part and inside the second part. It predicts the start edge for each case: a restart adds a full new gap, and a second-part carrier changes nothing. The end of the gap and the rise of the FIFO flag can also coincide. For this, the bench holds the flag low past the computed gap end and expects the start on the edge where the flag is first seen.

// File: rtl/tx_defer_pkg.sv
// Package: shared state encoding for the transmit deferral timer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tx_defer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DEFER = 3'd1,
        ST_GAP1  = 3'd2,
        ST_GAP2  = 3'd3,
        ST_GO    = 3'd4
    } defer_state_e;

endpackage

// File: rtl/tx_gap_len.sv
// Module: tx_gap_len
// Derives the second gap part length from the first part and the total,
// clamped at zero, and selects the limit for the active part.
// Assumes both inputs are unsigned bit-time counts of equal width.
module tx_gap_len #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] part1_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             sel_part2_i,
    output logic [CNT_W-1:0] part2_len_o,
    output logic [CNT_W-1:0] limit_o
);

    // Clamp the second part at zero when the total does not exceed part one.
    always_comb begin
        if (total_i > part1_i) begin
            part2_len_o = total_i - part1_i;
        end else begin
            part2_len_o = '0;
        end
    end

    // Pick the limit that the shared counter compares against.
    always_comb begin
        limit_o = sel_part2_i ? part2_len_o : part1_i;
    end

endmodule

// File: rtl/tx_gap_counter.sv
// Module: tx_gap_counter
// Counts bit ticks up to a limit and reports when the limit is reached.
// Assumes clear has priority and the limit is held steady while counting.
module tx_gap_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // Done once the counted ticks reach the selected limit.
    always_comb begin
        done_o = (cnt_q >= limit_i);
    end

    // Advance on ticks while running, stop at the limit, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && tick_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> $stable(cnt_q)); // R7

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && done_o) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/tx_defer_fsm.sv
// Module: tx_defer_fsm
// Sequences idle, deferral, both gap parts and the start pulse.
// Assumes the counter reports done for the limit of the current part.
module tx_defer_fsm
    import tx_defer_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         carrier_i,
    input  logic         frame_req_i,
    input  logic         fifo_ready_i,
    input  logic         gap_done_i,
    output defer_state_e state_o,
    output logic         cnt_clr_o,
    output logic         cnt_run_o,
    output logic         tx_start_o,
    output logic         deferring_o
);

    defer_state_e state_q;
    defer_state_e state_d;

    // Next-state selection; carrier beats the gap-done flag in part one.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_req_i) state_d = ST_DEFER;
            ST_DEFER: if (!carrier_i)  state_d = ST_GAP1;
            ST_GAP1: begin
                if (carrier_i)       state_d = ST_DEFER;
                else if (gap_done_i) state_d = ST_GAP2;
            end
            ST_GAP2:  if (gap_done_i && fifo_ready_i) state_d = ST_GO;
            ST_GO:    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter control: clear on every state change, run in the gap parts.
    always_comb begin
        cnt_clr_o = (state_d != state_q) || (state_q == ST_DEFER) || (state_q == ST_IDLE);
        cnt_run_o = ((state_q == ST_GAP1) && !carrier_i) || (state_q == ST_GAP2);
    end

    // Outputs decoded from the registered state.
    always_comb begin
        state_o     = state_q;
        tx_start_o  = (state_q == ST_GO);
        deferring_o = (state_q == ST_DEFER) || (state_q == ST_GAP1);
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |=> !tx_start_o); // R8

    AST_NO_START_DEFERRING: assert property (@(posedge clk) disable iff (!rst_n)
        deferring_o |-> !tx_start_o); // R2

    AST_START_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start_o) |-> $past(fifo_ready_i)); // R6

    AST_GAP1_CARRIER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP1 && carrier_i) |=> (state_q == ST_DEFER)); // R3

    AST_GAP2_IGNORES_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP2) |=> (state_q != ST_DEFER && !deferring_o)); // R4

endmodule

// File: rtl/tx_defer_ipg.sv
// Module: tx_defer_ipg (top)
// Decides when a half-duplex transmitter may start a frame: defers on
// carrier, applies a two-part gap in bit ticks, waits for FIFO fill.
// Assumes carrier_i is already synchronous to clk.
module tx_defer_ipg
    import tx_defer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_i,
    input  logic             bit_tick_i,
    input  logic [CNT_W-1:0] gap_part1_i,
    input  logic [CNT_W-1:0] gap_total_i,
    input  logic             fifo_ready_i,
    input  logic             frame_req_i,
    output logic             tx_start_o,
    output logic             deferring_o
);

    defer_state_e     state;
    logic             cnt_clr;
    logic             cnt_run;
    logic             gap_done;
    logic [CNT_W-1:0] part2_len;
    logic [CNT_W-1:0] limit;

    tx_gap_len #(.CNT_W(CNT_W)) u_len (
        .part1_i     (gap_part1_i),
        .total_i     (gap_total_i),
        .sel_part2_i (state == ST_GAP2),
        .part2_len_o (part2_len),
        .limit_o     (limit)
    );

    tx_gap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .run_i   (cnt_run),
        .tick_i  (bit_tick_i),
        .limit_i (limit),
        .done_o  (gap_done)
    );

    tx_defer_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier_i    (carrier_i),
        .frame_req_i  (frame_req_i),
        .fifo_ready_i (fifo_ready_i),
        .gap_done_i   (gap_done),
        .state_o      (state),
        .cnt_clr_o    (cnt_clr),
        .cnt_run_o    (cnt_run),
        .tx_start_o   (tx_start_o),
        .deferring_o  (deferring_o)
    );

    AST_ZERO_PART2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP2 && gap_total_i <= gap_part1_i && fifo_ready_i) |=> tx_start_o); // R5

endmodule

// File: tb/tb_tx_defer_ipg.sv
module tb_tx_defer_ipg;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic carrier = 0, tick = 1, fifo_ok = 1, req = 0;
    logic [CNT_W-1:0] p1 = 8'd10, ptot = 8'd16;
    logic tx_start, deferring;

    int cyc = 0;
    int n_chk = 0, n_bad = 0, n_seen = 0;
    int exp_q[$];
    string tag_q[$];
    logic prev_start = 0;

    tx_defer_ipg #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .bit_tick_i(tick),
        .gap_part1_i(p1), .gap_total_i(ptot), .fifo_ready_i(fifo_ok),
        .frame_req_i(req), .tx_start_o(tx_start), .deferring_o(deferring));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected start edge whenever a start pulse appears.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_start && prev_start) check(0, "R8 pulse longer than one cycle", 1, 0);
            if (tx_start && !prev_start) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6/R8 unexpected start", cyc, -1);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cyc == e, t, cyc, e);
                end
                n_seen++;
            end
            prev_start = tx_start;
        end
    end

    function automatic int len2();
        return (ptot > p1) ? int'(ptot) - int'(p1) : 0;
    endfunction

    // Driver: push the predicted start edge and wait for the frame to finish.
    task automatic expect_start(input int edge_no, input string tag);
        exp_q.push_back(edge_no);
        tag_q.push_back(tag);
    endtask

    task automatic finish_frame();
        int target;
        target = n_seen + 1;
        wait (n_seen == target);
        @(negedge clk);
        req = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        check(tx_start == 0 && deferring == 0, "R1 reset outputs", {tx_start, deferring}, 0);
        rst_n = 1;
        @(negedge clk);
        check(deferring == 0, "R1 idle after reset", deferring, 0);

        // Basic latency, tick every cycle.
        e0 = cyc + 1; req = 1;
        expect_start(e0 + 10 + len2() + 3, "R9 basic latency");
        @(negedge clk);
        check(deferring == 1, "R2 deferring after request", deferring, 1);
        finish_frame();

        // Carrier high on request: defer until it drops.
        carrier = 1; req = 1;
        repeat (6) @(negedge clk);
        check(deferring == 1 && tx_start == 0, "R2 deferring under carrier", deferring, 1);
        carrier = 0;
        expect_start(cyc + 1 + 10 + len2() + 2, "R2 start after carrier drop");
        finish_frame();

        // Carrier returns inside part one: full restart.
        e0 = cyc + 1; req = 1;
        repeat (4) @(negedge clk);
        carrier = 1;
        @(negedge clk);
        carrier = 0;
        expect_start(cyc + 1 + 10 + len2() + 2, "R3 restart in part one");
        @(negedge clk);
        check(deferring == 1, "R3 deferring after restart", deferring, 1);
        finish_frame();

        // Carrier inside part two: ignored.
        e0 = cyc + 1; req = 1;
        expect_start(e0 + 10 + len2() + 3, "R4 carrier ignored in part two");
        repeat (14) @(negedge clk);
        carrier = 1;
        check(deferring == 0, "R4 not deferring in part two", deferring, 0);
        @(negedge clk);
        carrier = 0;
        finish_frame();

        // Total not above part one: zero part two.
        ptot = 8'd8;
        e0 = cyc + 1; req = 1;
        expect_start(e0 + 10 + 0 + 3, "R5 zero second part");
        finish_frame();
        ptot = 8'd10;
        e0 = cyc + 1; req = 1;
        expect_start(e0 + 10 + 0 + 3, "R5 equal lengths");
        finish_frame();
        ptot = 8'd16;

        // FIFO not ready until after the gap end.
        fifo_ok = 0;
        e0 = cyc + 1; req = 1;
        repeat (40) @(negedge clk);
        check(tx_start == 0, "R6 held while FIFO low", tx_start, 0);
        fifo_ok = 1;
        expect_start(cyc + 1, "R6 start on FIFO rise");
        finish_frame();

        // Tick stalled: no progress, then resume.
        tick = 0;
        e0 = cyc + 1; req = 1;
        repeat (50) @(negedge clk);
        check(tx_start == 0 && deferring == 1, "R7 no progress without tick", tx_start, 0);
        tick = 1;
        expect_start(cyc + 1 + 10 + len2() + 1, "R7 resume on tick");
        finish_frame();

        // Standard 96-bit gap split 64/96.
        p1 = 8'd64; ptot = 8'd96;
        e0 = cyc + 1; req = 1;
        expect_start(e0 + 64 + 32 + 3, "R9 standard gap");
        finish_frame();

        check(exp_q.size() == 0, "R8 all starts seen", exp_q.size(), 0);
        check(tx_start == 0 && deferring == 0, "R8 idle after frame", deferring, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule